// File: doc/BRIEF.md
# I/O Access Recovery Timer

This block sits between a source of bus requests and the bus, and keeps a minimum number of bus clocks between one completed I/O access and the start of the next I/O access. A 3-bit recovery code sets that gap. Code zero means no gap. Every other code picks a power of two from 2 to 128 clocks. The code is held in a small register. A write strobe loads it, and reset sets it to the 32-clock setting.

Requests travel over a valid/ready stream. Each request carries a data word and a flag that marks it as I/O or memory. Memory requests go straight through and are never held by the recovery logic. An I/O request is held in two cases: while an earlier I/O access has been granted but has not yet reported completion, and while the recovery count loaded at that completion is still above zero.

Back-pressure rules:
- The downstream ready goes back upstream unchanged whenever a request is allowed through.
- The downstream valid never depends on the downstream ready.
- Once the block offers a request downstream, it keeps offering it as long as the source holds it.

The bus side reports the end of each I/O access with a one-clock completion strobe.

Top module: `iort_timer`

## Requirements
- R1: Recovery codes 001, 010 and 011 give gaps of 2, 4 and 8 clocks: after the completion strobe is sampled, the next I/O request is held for exactly that many cycles.
- R2: Code 000 gives no gap. Codes 100, 101, 110 and 111 give gaps of 16, 32, 64 and 128 clocks.
- R3: After reset the recovery code is 101, so the first completed I/O access is followed by a 32-clock gap. With no access completed since reset, an I/O request passes at once.
- R4: The counter loads the gap when the completion strobe is sampled and counts down once per clock. An I/O request is accepted in the first cycle in which the count is zero.
- R5: After an I/O request is accepted, further I/O requests are held until the completion strobe for that access arrives.
- R6: Memory requests (io flag 0) are never held, neither by the recovery count nor by an outstanding I/O access.
- R7: A code written while a count is running does not change that count. It applies from the next completion onward.
- R8: A completion strobe that arrives while no I/O access is outstanding is ignored and loads no gap.
- R9: While a request is allowed, up_ready follows dn_ready. dn_valid is independent of dn_ready. The data word and io flag pass downstream unchanged.
- R10: A write strobe with a code loads the recovery code register on that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Load strobe for the recovery code |
| cfg_code | input | 3 | Recovery code to load |
| up_valid | input | 1 | Source offers a request |
| up_ready | output | 1 | Block accepts the request this cycle |
| up_io | input | 1 | 1 = I/O request, 0 = memory request |
| up_data | input | DATA_W | Request word |
| dn_valid | output | 1 | Request offered to the bus |
| dn_ready | input | 1 | Bus accepts the offered request |
| dn_io | output | 1 | I/O flag of the offered request |
| dn_data | output | DATA_W | Word of the offered request |
| io_done | input | 1 | One-clock strobe: the granted I/O access finished |

## Verification
The bench builds the block with its default parameters: a 3-bit code, which makes the full 128-clock gap reachable, and a 16-bit data word. Under these settings it steps through all eight codes and counts the exact number of stalled cycles for each one. The 16-bit word lets every request carry a distinct pattern, so the scoreboard can tell each forwarded request from its neighbours. The same settings also cover the corner cases: a code change during a running count, a completion strobe that arrives while the block is idle, and back-pressure from the bus side.

// File: rtl/iort_pkg.sv
package iort_pkg;
  localparam int unsigned CODE_W = 3;
  localparam int unsigned CNT_W  = 1 << CODE_W;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [CNT_W-1:0]  gap_t;

  // Code 0 means no gap; any other code n gives a gap of 2**n clocks.
  function automatic gap_t gap_of(code_t c);
    gap_t g;
    if (c == '0) g = '0;
    else         g = gap_t'(1) << c;
    return g;
  endfunction
endpackage

// File: rtl/iort_code_reg.sv
module iort_code_reg
  import iort_pkg::*;
#(
  parameter code_t RESET_CODE = code_t'(5)
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr,
  input  code_t din,
  output code_t code_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  code_q <= RESET_CODE;
    else if (wr) code_q <= din;
  end

  // R10
  code_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> code_q == $past(din));
endmodule

// File: rtl/iort_recovery.sv
module iort_recovery
  import iort_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fire_io,
  input  logic io_done,
  input  gap_t gap,
  output logic io_clear
);
  gap_t cnt_q;
  logic busy_q;
  logic done_ok;

  // A completion strobe counts only while an I/O access is outstanding.
  assign done_ok  = io_done && busy_q;
  assign io_clear = (cnt_q == '0) && !busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
    end else if (done_ok) begin
      busy_q <= 1'b0;
    end else if (fire_io) begin
      busy_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (done_ok) begin
      cnt_q <= gap;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R4
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) && !done_ok |=> cnt_q == gap_t'($past(cnt_q) - 1'b1));
  // R7
  load_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_ok |=> cnt_q == $past(gap));
  // R5
  busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_io |=> busy_q);
  // R8
  stray_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_done && !busy_q && (cnt_q == '0) |=> cnt_q == '0);
endmodule

// File: rtl/iort_gate.sv
module iort_gate #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              up_valid,
  output logic              up_ready,
  input  logic              up_io,
  input  logic [DATA_W-1:0] up_data,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic              dn_io,
  output logic [DATA_W-1:0] dn_data,
  input  logic              io_clear,
  output logic              fire_io
);
  logic pass;

  assign pass     = !up_io || io_clear;
  assign dn_valid = up_valid && pass;
  assign up_ready = dn_ready && pass;
  assign dn_io    = up_io;
  assign dn_data  = up_data;
  assign fire_io  = dn_valid && dn_ready && dn_io;

  always_comb begin
    // R6
    no_mem_stall_chk: assert (!(up_valid && !up_io && dn_ready) || up_ready);
  end
endmodule

// File: rtl/iort_timer.sv
module iort_timer
  import iort_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned RESET_CODE = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [2:0]        cfg_code,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic              up_io,
  input  logic [DATA_W-1:0] up_data,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic              dn_io,
  output logic [DATA_W-1:0] dn_data,
  input  logic              io_done
);
  code_t code_q;
  gap_t  gap;
  logic  io_clear;
  logic  fire_io;

  iort_code_reg #(.RESET_CODE(code_t'(RESET_CODE))) u_code (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .din(code_t'(cfg_code)), .code_q(code_q)
  );

  assign gap = gap_of(code_q);

  iort_recovery u_rec (
    .clk(clk), .rst_n(rst_n), .fire_io(fire_io), .io_done(io_done),
    .gap(gap), .io_clear(io_clear)
  );

  iort_gate #(.DATA_W(DATA_W)) u_gate (
    .up_valid(up_valid), .up_ready(up_ready), .up_io(up_io), .up_data(up_data),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_io(dn_io), .dn_data(dn_data),
    .io_clear(io_clear), .fire_io(fire_io)
  );

  // R5
  no_double_io_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_io |=> !fire_io);
  // R9
  hold_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && !dn_ready && up_valid && $stable(up_io) |=> dn_valid);
  // R4
  gap_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_done && $past(fire_io) && (gap != '0) |=> !fire_io);
endmodule

// File: tb/test_iort_timer.sv
`timescale 1ns/1ps
module test_iort_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_code = '0;
  logic        up_valid = 1'b0;
  logic        up_ready;
  logic        up_io = 1'b0;
  logic [15:0] up_data = '0;
  logic        dn_valid;
  logic        dn_ready = 1'b1;
  logic        dn_io;
  logic [15:0] dn_data;
  logic        io_done = 1'b0;

  int errs = 0;
  int checks = 0;
  bit finished = 1'b0;

  typedef struct { logic io; logic [15:0] data; } item_t;
  item_t sb_q[$];

  iort_timer i_iort_timer (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_code(cfg_code),
    .up_valid(up_valid), .up_ready(up_ready), .up_io(up_io), .up_data(up_data),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_io(dn_io), .dn_data(dn_data),
    .io_done(io_done)
  );

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int gap_model(input int c);
    return (c == 0) ? 0 : (1 << c);
  endfunction

  // Scoreboard monitor: pops one expected item per downstream handshake.
  always @(negedge clk) begin
    #1;
    if (rst_n && dn_valid && dn_ready) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R9 unexpected item", int'(dn_data), -1);
      end else begin
        item_t e;
        e = sb_q.pop_front();
        check(dn_data == e.data, "R9 data", int'(dn_data), int'(e.data));
        check(dn_io == e.io, "R9 io flag", int'(dn_io), int'(e.io));
      end
    end
  end

  // All tasks start and end at a falling edge.
  task automatic cfg(input int c);
    cfg_wr = 1'b1;
    cfg_code = 3'(c);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic do_done();
    io_done = 1'b1;
    @(negedge clk);
    io_done = 1'b0;
  endtask

  task automatic send(input bit io, input logic [15:0] pl, input int done_at,
                      input int hold, input int exp, input string tag);
    int stalls = 0;
    item_t it;
    it.io = io;
    it.data = pl;
    sb_q.push_back(it);
    up_valid = 1'b1;
    up_io = io;
    up_data = pl;
    forever begin
      io_done = (stalls == done_at);
      dn_ready = (stalls >= hold);
      #1;
      if (stalls < hold && (!io || done_at >= 0 || exp == hold))
        check(dn_valid == 1'b1, "R9 valid without ready", int'(dn_valid), 1);
      if (up_ready) break;
      stalls++;
      if (stalls > 1000) break;
      @(negedge clk);
    end
    @(negedge clk);
    up_valid = 1'b0;
    io_done = 1'b0;
    dn_ready = 1'b1;
    check(stalls == exp, tag, stalls, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(dn_valid == 1'b0, "reset dn_valid", int'(dn_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: nothing completed yet, so an I/O passes at once; default gap is 32
    send(1'b1, 16'hA001, -1, 0, 0, "R3 first io");
    do_done();
    send(1'b1, 16'hA002, -1, 0, 32, "R3 default gap 32");

    // R1 R2 R10: sweep every code
    for (int c = 0; c < 8; c++) begin
      cfg(c);
      do_done();
      send(1'b1, 16'hB000 + 16'(c), -1, 0, gap_model(c),
           (c >= 1 && c <= 3) ? "R1 code gap" : "R2 code gap");
    end

    // R6: memory passes during a running count; R4 exact remaining count
    do_done();
    send(1'b0, 16'hC001, -1, 0, 0, "R6 mem during count");
    send(1'b1, 16'hC002, -1, 0, 127, "R4 remaining count");

    // R6: memory passes while an I/O is outstanding
    send(1'b0, 16'hC003, -1, 0, 0, "R6 mem while busy");

    // R5: I/O held until completion, then the full gap
    send(1'b1, 16'hC004, 3, 0, 3 + 1 + 128, "R5 busy then gap");

    // R7: code change mid-count affects only the next completion
    cfg(3);
    do_done();
    cfg(0);
    send(1'b1, 16'hD001, -1, 0, 7, "R7 old gap kept");
    do_done();
    send(1'b1, 16'hD002, -1, 0, 0, "R7 new gap used");

    // R8: a stray completion with no I/O outstanding loads nothing
    do_done();
    cfg(7);
    do_done();
    send(1'b1, 16'hE001, -1, 0, 0, "R8 stray done ignored");

    // R9: back-pressure from the bus side
    cfg(0);
    do_done();
    send(1'b1, 16'hF001, -1, 3, 3, "R9 io back-pressure");
    send(1'b0, 16'hF002, -1, 2, 2, "R9 mem back-pressure");

    repeat (3) @(negedge clk);
    check(sb_q.size() == 0, "R9 scoreboard drained", sb_q.size(), 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule